// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 512K words by 8 bits. The host presents one request at a time as a single-cycle pulse: a write with an address and a data byte, or a read with an address. The sequencer turns each request into a timed pattern on the RAM pins: a 19-bit address, active-low select, write strobe and output-enable lines, and an 8-bit data bus split into separate outgoing value, incoming value and drive-enable signals.

Every phase of the pattern lasts a whole number of clock cycles. These counts are worked out at elaboration from the memory's nanosecond timing limits and the clock period, using ceiling division and a floor of one cycle. Writes are ended by the write strobe. A read holds the select and output-enable lines low for the access time and returns the byte with a one-cycle valid pulse. It then leaves the bus idle long enough for the memory's drivers to release it. A parameter selects whether output enable stays low during writes. In that mode the write strobe is lengthened, and the sequencer waits before driving data until the memory has let go of the bus.

Top module: `asram_ctl`

## Requirements
- R1: After reset and whenever no request is in progress, `ready` is 1, `ram_cs_n`, `ram_we_n` and `ram_oe_n` are 1, `ram_dq_oe` is 0, and with `req` held at 0 the RAM select stays high.
- R2: A request is taken only while `ready` is 1. A `req` pulse that arrives while an operation is in progress is dropped. It writes nothing, and `ready` does not fall again once the current operation ends.
- R3: A write (`we`=1) first holds `ram_cs_n`=0 with `ram_we_n`=1 for one setup cycle. It then holds `ram_we_n` low for 4 cycles at the default timing (200 MHz clock), and `ram_addr` does not change while `ram_we_n` is low.
- R4: In the default mode (output enable high during writes), `ram_oe_n` stays 1 for the whole write. `ram_dq_oe` rises together with the falling edge of `ram_we_n`, and `ram_dq_oe` is never 1 while the RAM could be driving (select low, output enable low, write strobe high).
- R5: A write asserts `wdone` for exactly one cycle, in the same cycle that `ready` returns. The write keeps `ready` low for 6 cycles.
- R6: A read (`we`=0) holds `ram_cs_n`=0, `ram_oe_n`=0 and `ram_we_n`=1 for 5 cycles. It then presents the stored byte on `rdata` with `rvalid` high for exactly one cycle, the cycle right after the access phase.
- R7: After a read, the select and output-enable lines are high for 3 cycles before `ready` returns. The read keeps `ready` low for 8 cycles.
- R8: With output enable held low during writes (`OE_LOW_WRITE`=1), `ram_oe_n` is 0 through the setup and strobe cycles (7 cycles) and 1 in the hold cycle. `ram_we_n` is low for 6 cycles, `ram_dq_oe` rises on the 4th low cycle (index 3), and `ready` is low for 8 cycles.
- R9: Zero-nanosecond hold and recovery limits still produce one hold cycle. After `ram_we_n` rises, the data drive, address and select stay active for exactly one cycle.
- R10: A byte written to an address is returned by a later read of that address. Other addresses keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request pulse, taken while ready is high |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 19 | Word address of the request |
| wdata | input | 8 | Byte to write |
| ready | output | 1 | Sequencer idle, able to accept a request |
| rdata | output | 8 | Byte returned by the last read |
| rvalid | output | 1 | One-cycle pulse: rdata is new |
| wdone | output | 1 | One-cycle pulse: write finished |
| ram_addr | output | 19 | RAM address lines |
| ram_cs_n | output | 1 | RAM select, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_dq_o | output | 8 | Value driven onto the RAM data bus |
| ram_dq_i | input | 8 | Value seen on the RAM data bus |
| ram_dq_oe | output | 1 | Drive enable for the RAM data bus |

## Verification
The hardest case to reach from the ports is a request that arrives while an operation is already running. The accept logic must drop it, and its only visible trace would be a stray write. The bench raises a second write request in the middle of a write strobe, aimed at another address. It then confirms that `ready` stays high afterwards and that reading that address returns its initial contents. The stretched-strobe write mode is reached through a second instance built with output enable held low, whose strobe length and drive start are measured cycle by cycle.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC,
    ST_RTURN
  } asram_state_e;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } asram_pins_t;

  // whole clock cycles covering a time in ns, never fewer than one
  function automatic int ns2cyc(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
`timescale 1ns/1ps
module asram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  output logic [CNT_W-1:0] idx_q,
  output logic [CNT_W-1:0] idx_d
);

  always_comb begin
    if (clear) idx_d = '0;
    else       idx_d = idx_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else     idx_q <= idx_d;
  end

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int CNT_W    = 3,
  parameter int AS_CYC   = 1,
  parameter int WP_CYC   = 4,
  parameter int HOLD_CYC = 1,
  parameter int ACC_CYC  = 5,
  parameter int TURN_CYC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             we,
  input  logic [CNT_W-1:0] idx_q,
  output asram_state_e     state_q,
  output asram_state_e     state_d,
  output logic             accept,
  output logic             sample,
  output logic             clear
);

  localparam logic [CNT_W-1:0] AS_LAST   = CNT_W'(AS_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LAST   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] ACC_LAST  = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYC - 1);

  logic [CNT_W-1:0] last_idx;
  logic             phase_end;

  always_comb begin
    unique case (state_q)
      ST_WSETUP: last_idx = AS_LAST;
      ST_WPULSE: last_idx = WP_LAST;
      ST_WHOLD:  last_idx = HOLD_LAST;
      ST_RACC:   last_idx = ACC_LAST;
      ST_RTURN:  last_idx = TURN_LAST;
      default:   last_idx = '0;
    endcase
  end

  assign phase_end = (idx_q == last_idx);
  assign accept    = (state_q == ST_IDLE) && req;
  assign sample    = (state_q == ST_RACC) && phase_end;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req) state_d = we ? ST_WSETUP : ST_RACC;
      ST_WSETUP: if (phase_end) state_d = ST_WPULSE;
      ST_WPULSE: if (phase_end) state_d = ST_WHOLD;
      ST_WHOLD:  if (phase_end) state_d = ST_IDLE;
      ST_RACC:   if (phase_end) state_d = ST_RTURN;
      ST_RTURN:  if (phase_end) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign clear = (state_d != state_q) || (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/asram_pin_reg.sv
`timescale 1ns/1ps
module asram_pin_reg
  import asram_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int DATA_W       = 8,
  parameter int CNT_W        = 3,
  parameter int DRV_START    = 0,
  parameter bit OE_LOW_WRITE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              sample,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  asram_state_e      state_q,
  input  asram_state_e      state_d,
  input  logic [CNT_W-1:0]  idx_d,
  input  logic [DATA_W-1:0] ram_dq_i,
  output logic              ready,
  output logic              rvalid,
  output logic              wdone,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_o,
  output asram_pins_t       pins_q
);

  localparam logic WR_OE_N = ~OE_LOW_WRITE;

  asram_pins_t pins_d;
  logic        drv_ok;

  // strobe cycle from which the data bus may be driven
  generate
    if (DRV_START == 0) begin : g_drv_now
      assign drv_ok = 1'b1;
    end else begin : g_drv_late
      assign drv_ok = (idx_d >= CNT_W'(DRV_START));
    end
  endgenerate

  always_comb begin
    pins_d = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
    unique case (state_d)
      ST_WSETUP: pins_d = '{cs_n: 1'b0, we_n: 1'b1, oe_n: WR_OE_N, dq_oe: 1'b0};
      ST_WPULSE: pins_d = '{cs_n: 1'b0, we_n: 1'b0, oe_n: WR_OE_N, dq_oe: drv_ok};
      ST_WHOLD:  pins_d = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
      ST_RACC:   pins_d = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
      default:   pins_d = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q <= '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
      ready  <= 1'b1;
      rvalid <= 1'b0;
      wdone  <= 1'b0;
    end else begin
      pins_q <= pins_d;
      ready  <= (state_d == ST_IDLE);
      rvalid <= sample;
      wdone  <= (state_q == ST_WHOLD) && (state_d == ST_IDLE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr <= '0;
      ram_dq_o <= '0;
      rdata    <= '0;
    end else begin
      if (accept) begin
        ram_addr <= addr;
        ram_dq_o <= wdata;
      end
      if (sample) rdata <= ram_dq_i;
    end
  end

endmodule

// File: rtl/asram_ctl.sv
`timescale 1ns/1ps
module asram_ctl
  import asram_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int DATA_W       = 8,
  parameter int CLK_NS       = 5,
  parameter int T_AS_NS      = 3,
  parameter int T_WP_NS      = 17,
  parameter int T_AW_NS      = 20,
  parameter int T_DW_NS      = 15,
  parameter int T_DH_NS      = 0,
  parameter int T_WR_NS      = 0,
  parameter int T_WHZ_NS     = 15,
  parameter int T_RC_NS      = 25,
  parameter int T_AA_NS      = 25,
  parameter int T_OE_NS      = 12,
  parameter int T_OHZ_NS     = 12,
  parameter bit OE_LOW_WRITE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              wdone,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_cs_n,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [DATA_W-1:0] ram_dq_o,
  input  logic [DATA_W-1:0] ram_dq_i,
  output logic              ram_dq_oe
);

  localparam int AS_CYC    = ns2cyc(T_AS_NS, CLK_NS);
  localparam int DW_CYC    = ns2cyc(T_DW_NS, CLK_NS);
  localparam int WHZ_CYC   = ns2cyc(T_WHZ_NS, CLK_NS);
  localparam int DRV_START = OE_LOW_WRITE ? WHZ_CYC : 0;
  localparam int WP_CYC    = imax(ns2cyc(T_WP_NS, CLK_NS),
                                  imax(ns2cyc(T_AW_NS, CLK_NS) - AS_CYC,
                                       DRV_START + DW_CYC));
  localparam int HOLD_CYC  = imax(ns2cyc(T_DH_NS, CLK_NS), ns2cyc(T_WR_NS, CLK_NS));
  localparam int ACC_CYC   = imax(ns2cyc(T_RC_NS, CLK_NS),
                                  imax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS)));
  localparam int TURN_CYC  = ns2cyc(T_OHZ_NS, CLK_NS);
  localparam int MAX_CYC   = imax(imax(AS_CYC, WP_CYC), imax(imax(HOLD_CYC, ACC_CYC), TURN_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  asram_state_e     state_q, state_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             accept, sample, clear;
  asram_pins_t      pins_q;

  asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clear (clear),
    .idx_q (idx_q),
    .idx_d (idx_d)
  );

  asram_seq #(
    .CNT_W    (CNT_W),
    .AS_CYC   (AS_CYC),
    .WP_CYC   (WP_CYC),
    .HOLD_CYC (HOLD_CYC),
    .ACC_CYC  (ACC_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .we      (we),
    .idx_q   (idx_q),
    .state_q (state_q),
    .state_d (state_d),
    .accept  (accept),
    .sample  (sample),
    .clear   (clear)
  );

  asram_pin_reg #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .CNT_W        (CNT_W),
    .DRV_START    (DRV_START),
    .OE_LOW_WRITE (OE_LOW_WRITE)
  ) u_pins (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .sample   (sample),
    .addr     (addr),
    .wdata    (wdata),
    .state_q  (state_q),
    .state_d  (state_d),
    .idx_d    (idx_d),
    .ram_dq_i (ram_dq_i),
    .ready    (ready),
    .rvalid   (rvalid),
    .wdone    (wdone),
    .rdata    (rdata),
    .ram_addr (ram_addr),
    .ram_dq_o (ram_dq_o),
    .pins_q   (pins_q)
  );

  assign ram_cs_n  = pins_q.cs_n;
  assign ram_we_n  = pins_q.we_n;
  assign ram_oe_n  = pins_q.oe_n;
  assign ram_dq_oe = pins_q.dq_oe;

endmodule

// File: rtl/asram_ctl_chk.sv
`timescale 1ns/1ps
module asram_ctl_chk
  import asram_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int CLK_NS       = 5,
  parameter int T_WP_NS      = 17,
  parameter int T_WHZ_NS     = 15,
  parameter int T_DW_NS      = 15,
  parameter bit OE_LOW_WRITE = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              ready,
  input logic              rvalid,
  input logic              wdone,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_cs_n,
  input logic              ram_we_n,
  input logic              ram_oe_n,
  input logic              ram_dq_oe
);

  localparam int MIN_WP = OE_LOW_WRITE ?
                          imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_WHZ_NS + T_DW_NS, CLK_NS)) :
                          ns2cyc(T_WP_NS, CLK_NS);

  logic [15:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst)            low_cnt <= '0;
    else if (!ram_we_n) low_cnt <= low_cnt + 16'd1;
    else                low_cnt <= '0;
  end

  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> (ram_cs_n && ram_we_n && ram_oe_n && !ram_dq_oe));

  // R2
  accept_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(req));

  // R3
  addr_steady_chk: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |=> (ram_we_n || $stable(ram_addr)));

  // R3
  strobe_selected_chk: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> !ram_cs_n);

  // R3
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_we_n) |-> (low_cnt >= 16'(MIN_WP)));

  // R4
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    ram_dq_oe |-> (!ram_cs_n && (ram_oe_n || !ram_we_n)));

  // R5
  wdone_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wdone |-> (ready && !rvalid) ##1 !wdone);

  // R6
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid |=> !rvalid);

  // R7
  turn_released_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> (ram_oe_n && ram_cs_n && !ready));

  // R9
  hold_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_we_n) |-> (ram_dq_oe && !ram_cs_n));

endmodule

bind asram_ctl asram_ctl_chk #(
  .ADDR_W       (ADDR_W),
  .CLK_NS       (CLK_NS),
  .T_WP_NS      (T_WP_NS),
  .T_WHZ_NS     (T_WHZ_NS),
  .T_DW_NS      (T_DW_NS),
  .OE_LOW_WRITE (OE_LOW_WRITE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .ready     (ready),
  .rvalid    (rvalid),
  .wdone     (wdone),
  .ram_addr  (ram_addr),
  .ram_cs_n  (ram_cs_n),
  .ram_we_n  (ram_we_n),
  .ram_oe_n  (ram_oe_n),
  .ram_dq_oe (ram_dq_oe)
);

// File: tb/test_asram_ctl.sv
`timescale 1ns/1ps
module asram_model (
  input  logic [18:0] addr,
  input  logic        cs_n,
  input  logic        we_n,
  input  logic        oe_n,
  input  logic [7:0]  dq_o,
  input  logic        dq_oe,
  output logic [7:0]  dq_i
);
  logic [7:0] mem [1024];

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i) ^ 8'h5A;
  end

  assign dq_i = (!cs_n && !oe_n && we_n) ? mem[addr[9:0]] :
                (dq_oe ? dq_o : 8'hEE);

  always @(posedge we_n) begin
    if (!cs_n && dq_oe) mem[addr[9:0]] <= dq_o;
  end
endmodule

module test_asram_ctl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        sel = 1'b0;
  logic        h_req = 1'b0, h_we = 1'b0;
  logic [18:0] h_addr = '0;
  logic [7:0]  h_wdata = '0;

  logic        rdy0, rv0, wd0, cs0, we0, oe0, de0;
  logic [7:0]  rd0, dqo0, dqi0;
  logic [18:0] ra0;
  logic        rdy1, rv1, wd1, cs1, we1, oe1, de1;
  logic [7:0]  rd1, dqo1, dqi1;
  logic [18:0] ra1;

  asram_ctl i_asram_ctl (
    .clk(clk), .rst(rst), .req(h_req & ~sel), .we(h_we), .addr(h_addr), .wdata(h_wdata),
    .ready(rdy0), .rdata(rd0), .rvalid(rv0), .wdone(wd0), .ram_addr(ra0),
    .ram_cs_n(cs0), .ram_we_n(we0), .ram_oe_n(oe0), .ram_dq_o(dqo0),
    .ram_dq_i(dqi0), .ram_dq_oe(de0));

  asram_model u_mem0 (.addr(ra0), .cs_n(cs0), .we_n(we0), .oe_n(oe0),
                      .dq_o(dqo0), .dq_oe(de0), .dq_i(dqi0));

  asram_ctl #(.OE_LOW_WRITE(1'b1)) i_asram_ctl_oel (
    .clk(clk), .rst(rst), .req(h_req & sel), .we(h_we), .addr(h_addr), .wdata(h_wdata),
    .ready(rdy1), .rdata(rd1), .rvalid(rv1), .wdone(wd1), .ram_addr(ra1),
    .ram_cs_n(cs1), .ram_we_n(we1), .ram_oe_n(oe1), .ram_dq_o(dqo1),
    .ram_dq_i(dqi1), .ram_dq_oe(de1));

  asram_model u_mem1 (.addr(ra1), .cs_n(cs1), .we_n(we1), .oe_n(oe1),
                      .dq_o(dqo1), .dq_oe(de1), .dq_i(dqi1));

  logic        p_ready, p_rvalid, p_wdone, p_cs_n, p_we_n, p_oe_n, p_dq_oe;
  logic [7:0]  p_rdata;
  logic [18:0] p_addr;

  always_comb begin
    if (sel) begin
      p_ready = rdy1; p_rvalid = rv1; p_wdone = wd1; p_cs_n = cs1;
      p_we_n = we1; p_oe_n = oe1; p_dq_oe = de1; p_rdata = rd1; p_addr = ra1;
    end else begin
      p_ready = rdy0; p_rvalid = rv0; p_wdone = wd0; p_cs_n = cs0;
      p_we_n = we0; p_oe_n = oe0; p_dq_oe = de0; p_rdata = rd0; p_addr = ra0;
    end
  end

  int checks = 0;
  int fails = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // measurements of the last operation
  int r_busy, r_setup, r_welow, r_drv_first, r_drv_after, r_oe_low;
  int r_rv_cnt, r_rv_idx, r_rdata, r_wdone, r_acc, r_turn, r_moved, r_clash;

  task automatic run_op(input logic use1, input logic op_we, input logic [18:0] a,
                        input logic [7:0] d, input logic inject);
    logic [18:0] prev;
    r_busy = 0; r_setup = 0; r_welow = 0; r_drv_first = -1; r_drv_after = 0;
    r_oe_low = 0; r_rv_cnt = 0; r_rv_idx = -1; r_rdata = -1; r_wdone = 0;
    r_acc = 0; r_turn = 0; r_moved = 0; r_clash = 0; prev = '0;
    @(negedge clk);
    sel = use1; h_we = op_we; h_addr = a; h_wdata = d; h_req = 1'b1;
    @(negedge clk);
    h_req = 1'b0;
    for (int idx = 0; idx < 64; idx++) begin
      if (!p_ready) r_busy++;
      if (!p_cs_n && p_we_n && r_welow == 0 && !p_dq_oe && p_oe_n == !sel && op_we) r_setup++;
      if (!p_we_n) begin
        if (p_dq_oe && r_drv_first < 0) r_drv_first = r_welow;
        if (r_welow > 0 && p_addr != prev) r_moved++;
        prev = p_addr;
        r_welow++;
      end
      if (p_we_n && r_welow > 0 && p_dq_oe && !p_cs_n) r_drv_after++;
      if (op_we && !p_oe_n) r_oe_low++;
      if (p_dq_oe && !p_cs_n && !p_oe_n && p_we_n) r_clash++;
      if (!op_we && !p_cs_n && !p_oe_n && p_we_n) r_acc++;
      if (!op_we && !p_ready && p_cs_n && p_oe_n && p_we_n) r_turn++;
      if (p_rvalid) begin r_rv_cnt++; r_rv_idx = idx; r_rdata = int'(p_rdata); end
      if (p_wdone) r_wdone++;
      if (p_ready) break;
      if (inject && idx == 1) begin
        h_req = 1'b1; h_we = 1'b1; h_addr = 19'h00155; h_wdata = 8'hC3;
      end else begin
        h_req = 1'b0;
      end
      @(negedge clk);
    end
    h_req = 1'b0;
  endtask

  // {we, addr, data}; for a read the data field is the expected byte (R10)
  localparam int NVEC = 9;
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b1, 19'h00010, 8'hA5},
    {1'b1, 19'h7FFFF, 8'h3C},
    {1'b0, 19'h00010, 8'hA5},
    {1'b0, 19'h7FFFF, 8'h3C},
    {1'b1, 19'h00010, 8'h00},
    {1'b0, 19'h00010, 8'h00},
    {1'b0, 19'h00020, 8'h7A},
    {1'b1, 19'h40001, 8'hFF},
    {1'b0, 19'h40001, 8'hFF}
  };

  bit finished = 1'b0;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready after reset", int'(p_ready), 1);
    chk("R1 pins high after reset", int'({p_cs_n, p_we_n, p_oe_n}), 7);
    chk("R1 no drive after reset", int'(p_dq_oe), 0);
    chk("R1 no pulses after reset", int'({p_rvalid, p_wdone}), 0);
    begin
      int low_seen;
      low_seen = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (!p_cs_n || !p_ready) low_seen++;
      end
      chk("R1 idle without req", low_seen, 0);
    end

    for (int i = 0; i < NVEC; i++) begin
      logic        vw;
      logic [18:0] va;
      logic [7:0]  vd;
      vw = VEC[i][27]; va = VEC[i][26:8]; vd = VEC[i][7:0];
      run_op(1'b0, vw, va, vd, 1'b0);
      if (vw) begin
        chk("R3 setup cycles", r_setup, 1);
        chk("R3 strobe cycles", r_welow, 4);
        chk("R3 address moved in strobe", r_moved, 0);
        chk("R4 drive start", r_drv_first, 0);
        chk("R4 oe low in write", r_oe_low, 0);
        chk("R4 contention", r_clash, 0);
        chk("R5 wdone pulses", r_wdone, 1);
        chk("R5 busy cycles", r_busy, 6);
        chk("R9 hold drive cycles", r_drv_after, 1);
      end else begin
        chk("R6 access cycles", r_acc, 5);
        chk("R6 rvalid pulses", r_rv_cnt, 1);
        chk("R6 rvalid cycle", r_rv_idx, 5);
        chk("R10 read data", r_rdata, int'(vd));
        chk("R7 turnaround cycles", r_turn, 3);
        chk("R7 busy cycles", r_busy, 8);
      end
    end

    // R2: request during a running write is dropped
    run_op(1'b0, 1'b1, 19'h00100, 8'h11, 1'b1);
    chk("R2 first write busy", r_busy, 6);
    begin
      int drop;
      drop = 0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (!p_ready || !p_cs_n) drop++;
      end
      chk("R2 no second accept", drop, 0);
    end
    run_op(1'b0, 1'b0, 19'h00155, 8'h00, 1'b0);
    chk("R2 dropped write left memory", r_rdata, 32'h0F);
    run_op(1'b0, 1'b0, 19'h00100, 8'h00, 1'b0);
    chk("R10 accepted write stored", r_rdata, 32'h11);

    // R8: output enable held low during writes
    run_op(1'b1, 1'b1, 19'h00033, 8'h9C, 1'b0);
    chk("R8 strobe cycles", r_welow, 6);
    chk("R8 drive start", r_drv_first, 3);
    chk("R8 oe low cycles", r_oe_low, 7);
    chk("R8 busy cycles", r_busy, 8);
    chk("R8 hold drive cycles", r_drv_after, 1);
    chk("R8 contention", r_clash, 0);
    run_op(1'b1, 1'b0, 19'h00033, 8'h00, 1'b0);
    chk("R8 read back", r_rdata, 32'h9C);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule